// File: doc/BRIEF.md
# Converter Result Output Port

This block sits behind a data converter and presents each 16-bit result on one of two ports. A static port-select input chooses between them. The first is a parallel bus read with active-low chip select and read strobes. The second is a serial port that sends a framed stream, one bit at a time, with a frame signal around it. The result can leave the block as straight binary, or as two's complement, which is made by flipping the top bit.

Three pins are parallel data bits 4 to 6 when the parallel port is in use. When the serial port is in use they turn into configuration inputs: one picks the bit clock source, one sets the frame signal polarity, and one inverts the bit clock. The bit clock is either made inside the block by halving the system clock, or taken from outside and brought into the system clock domain through a synchronizer. A result that arrives while a serial frame is still going out waits in a single holding slot. It is sent after the current frame, so a frame is never cut short.

Top module: `result_port`

## Requirements
- R1: On a cycle with `res_valid` high, the block latches `res_data` unchanged when `fmt_straight` is 1, and with bit 15 flipped when it is 0. The latched word appears on the parallel bus from the cycle after that edge.
- R2: In parallel mode the bus {`bus_hi`, `mux_out`, `bus_lo`} shows the latched word, bits 15..7, 6..4 and 3..0 in that order, only while `cs_n` and `rd_n` are both 0. At all other times every bus bit is 0.
- R3: `bus_lo` is driven in both modes, gated the same way as in R2. In serial mode `mux_oe` is 0 and `mux_out` and `bus_hi` are 0. In parallel mode `mux_oe` is 1.
- R4: A serial frame sends the 16 coded bits MSB first. `ser_dout` is 0 outside a frame.
- R5: With `mux_in[0]`=0 (internal clock), the raw bit clock is the system clock divided by two and runs only during a frame. Each bit lasts 2 cycles: one cycle raw-low, then one cycle raw-high. The frame lasts 32 cycles, starting with the cycle after the capture edge. `sclk_oe` is 1.
- R6: With `mux_in[0]`=1 (external clock), `sclk_oe` is 0. The next bit is launched on each falling edge of `sclk_in` XOR `mux_in[2]`, seen through a two-flop synchronizer. A rising edge does not advance the data. The frame ends after the 16th falling edge.
- R7: `ser_sync` is active during a frame and idle otherwise. It is active high when `mux_in[1]`=0 and active low when `mux_in[1]`=1. This holds for both clock sources.
- R8: `sclk_out` equals the raw internal bit clock XOR `mux_in[2]`. It therefore idles at the value of `mux_in[2]`.
- R9: A result captured during a frame does not disturb that frame. It is sent, starting one idle cycle after the frame ends. If a second result arrives while one is already waiting, the newer result replaces it.
- R10: In serial mode a frame starts on the edge that captures a result while the port is idle. In parallel mode no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_data | input | 16 | Raw conversion result |
| res_valid | input | 1 | One-cycle strobe: res_data is new |
| fmt_straight | input | 1 | 1 = straight binary, 0 = two's complement |
| ser_sel | input | 1 | 0 = parallel port, 1 = serial port |
| cs_n | input | 1 | Parallel chip select, active low |
| rd_n | input | 1 | Parallel read, active low |
| bus_lo | output | 4 | Bus bits 3..0, always driven |
| mux_in | input | 3 | Serial config: [0] clock source, [1] frame polarity, [2] clock invert |
| mux_out | output | 3 | Bus bits 6..4 in parallel mode |
| mux_oe | output | 1 | Output enable for the shared bits |
| bus_hi | output | 9 | Bus bits 15..7 |
| ser_dout | output | 1 | Serial data |
| ser_sync | output | 1 | Frame signal |
| sclk_out | output | 1 | Bit clock driven by the block |
| sclk_oe | output | 1 | Output enable for the bit clock pin |
| sclk_in | input | 1 | Bit clock received from outside |

## Verification
The latched word is registered on the capture edge, and the parallel bus is combinational on top of it. The bench therefore reads the bus in the falling half of the cycle after the strobe, once the strobes have been set. With the internal clock, bit n of a frame is due in cycles 2n and 2n+1 after the capture edge, and the frame signal drops in cycle 32. The bench samples every one of those cycles on the falling clock edge. With the external clock, a level change on `sclk_in` takes three system edges to move the data. The bench therefore holds each half period for four cycles and samples just before it drives the next level change.

// File: rtl/result_port_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and field indices for the result output port.
// Assumes a result word of at least 8 bits so that bits 6..4 exist.
package result_port_pkg;
    localparam int RES_W       = 16;   // result word width
    localparam int LO_W        = 4;    // always-driven low bus bits
    localparam int MUX_W       = 3;    // bus bits shared with serial config
    localparam int SYNC_STAGES = 2;    // external clock synchronizer depth

    // meaning of the shared pins when the serial port is selected
    localparam int CFG_EXT_CLK  = 0;
    localparam int CFG_SYNC_INV = 1;
    localparam int CFG_SCLK_INV = 2;
endpackage

// File: rtl/result_capture.sv
`timescale 1ns/1ps
// Module: result_capture
// Applies the output coding to each incoming result and keeps the last
// coded word for the parallel bus. Also passes the coded word on at once,
// so that the serial framer can load it in the capture cycle.
// Assumes res_valid is a single-cycle strobe in the clk domain.
module result_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] res_data,
    input  logic         res_valid,
    input  logic         fmt_straight,
    output logic [W-1:0] coded_now,
    output logic [W-1:0] word_q
);
    localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

    // Coding: flip the MSB for two's complement output.
    always_comb begin
        coded_now = fmt_straight ? res_data : (res_data ^ MSB_MASK);
    end

    // Latch the coded word on every valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (res_valid) begin
            word_q <= coded_now;
        end
    end

    // R1: the latched word only changes on a strobe
    p_word_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(word_q));
endmodule

// File: rtl/par_bus_drv.sv
`timescale 1ns/1ps
// Module: par_bus_drv
// Drives the parallel data bus from the latched word. The bus is blanked
// unless chip select and read are both low. In serial mode the shared bits
// are released (output enable low) and the upper bits are held at zero.
// The low nibble is driven in both modes.
// Assumes W >= 8.
module par_bus_drv #(
    parameter int W     = 16,
    parameter int LO_W  = 4,
    parameter int MUX_W = 3
) (
    input  logic [W-1:0]            word_q,
    input  logic                    ser_sel,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [LO_W-1:0]         bus_lo,
    output logic [MUX_W-1:0]        mux_out,
    output logic                    mux_oe,
    output logic [W-LO_W-MUX_W-1:0] bus_hi
);
    localparam int MID_LSB = LO_W;
    localparam int HI_LSB  = LO_W + MUX_W;

    logic         rd_en;
    logic [W-1:0] gated;

    // Read strobe decode: both active-low controls asserted.
    always_comb begin
        rd_en = !cs_n && !rd_n;
        gated = rd_en ? word_q : '0;
    end

    // Split the bus by mode: shared and upper bits go quiet in serial mode.
    always_comb begin
        bus_lo  = gated[LO_W-1:0];
        mux_oe  = !ser_sel;
        mux_out = ser_sel ? '0 : gated[HI_LSB-1:MID_LSB];
        bus_hi  = ser_sel ? '0 : gated[W-1:HI_LSB];
    end

    // R2: outside a read the whole bus is zero
    p_bus_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (bus_lo == '0 && mux_out == '0 && bus_hi == '0));
endmodule

// File: rtl/ser_clk_unit.sv
`timescale 1ns/1ps
// Module: ser_clk_unit
// Produces the launch pulse that moves the serial data on by one bit.
// Internal source: the system clock halved, running only during a frame.
// External source: sclk_in passes a synchronizer chain, is inverted if
// asked, and each falling edge of the result gives one launch.
// Assumes the clock source select is static while a frame is in flight.
module ser_clk_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_sel,
    input  logic ext_sel,
    input  logic sclk_inv,
    input  logic frame_act,
    input  logic sclk_in,
    output logic launch,
    output logic sclk_out,
    output logic sclk_oe
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   ext_prev;
    logic                   ext_raw;
    logic                   phase;
    logic                   launch_int;
    logic                   launch_ext;

    // Synchronizer chain for the external clock.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            // First stage samples the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= sclk_in;
            end
        end else begin : g_next
            // Later stages follow the one before.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    // Remove the pin inversion so that the falling edge always launches.
    always_comb begin
        ext_raw = chain[SYNC_STAGES-1] ^ sclk_inv;
    end

    // Keep the previous external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_raw;
    end

    // Internal divide-by-two, held low between frames.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase <= 1'b0;
        else if (!frame_act) phase <= 1'b0;
        else                 phase <= ~phase;
    end

    // Launch pulse selection and bit clock pin drive.
    always_comb begin
        launch_int = frame_act && phase;
        launch_ext = frame_act && ext_prev && !ext_raw;
        launch     = ext_sel ? launch_ext : launch_int;
        sclk_oe    = ser_sel && !ext_sel;
        sclk_out   = sclk_oe ? ((phase && frame_act) ^ sclk_inv) : 1'b0;
    end

    // R5: internal launches are never on two cycles in a row
    p_int_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_sel && launch) |=> (!launch || ext_sel));
    // R8: the driven bit clock rests at the invert setting between frames
    p_sclk_rest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sel && !ext_sel && !frame_act) |-> (sclk_out == sclk_inv));
endmodule

// File: rtl/ser_framer.sv
`timescale 1ns/1ps
// Module: ser_framer
// Shifts a coded word out MSB first, one bit per launch pulse, and keeps
// the frame signal active for the whole frame. A word captured during a
// frame goes into a single holding slot (newest wins). It starts after one
// idle cycle with the frame signal inactive.
// Assumes the launch pulse is only seen while frame_act is high.
module ser_framer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_sel,
    input  logic         cap_valid,
    input  logic [W-1:0] cap_word,
    input  logic         launch,
    input  logic         sync_inv,
    output logic         ser_dout,
    output logic         ser_sync,
    output logic         frame_act
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic             busy;
    logic [W-1:0]     shreg;
    logic [CNT_W-1:0] bit_cnt;
    logic             pend_vld;
    logic [W-1:0]     pend_q;
    logic             start_pend;
    logic             start_new;
    logic             hold_new;

    // Decide what a new strobe does: start a frame now, or wait.
    always_comb begin
        start_pend = !busy && ser_sel && pend_vld;
        start_new  = !busy && ser_sel && !pend_vld && cap_valid;
        hold_new   = ser_sel && cap_valid && (busy || pend_vld);
    end

    // Frame sequencing: load, shift on launch, stop after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (busy) begin
            if (launch) begin
                if (bit_cnt == LAST_BIT) begin
                    busy <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    shreg   <= {shreg[W-2:0], 1'b0};
                end
            end
        end else if (start_pend) begin
            busy    <= 1'b1;
            shreg   <= pend_q;
            bit_cnt <= '0;
        end else if (start_new) begin
            busy    <= 1'b1;
            shreg   <= cap_word;
            bit_cnt <= '0;
        end
    end

    // Holding slot for a result that cannot be sent yet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld <= 1'b0;
            pend_q   <= '0;
        end else if (hold_new) begin
            pend_vld <= 1'b1;
            pend_q   <= cap_word;
        end else if (start_pend) begin
            pend_vld <= 1'b0;
        end
    end

    // Serial pin drive with the polarity applied to the frame signal.
    always_comb begin
        frame_act = busy;
        ser_dout  = busy ? shreg[W-1] : 1'b0;
        ser_sync  = ser_sel ? (busy ^ sync_inv) : 1'b0;
    end

    // R4: data holds between launches
    p_hold_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !launch) |=> $stable(ser_dout));
    // R4: a frame only ends on a launch
    p_end_on_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(launch));
    // R9: a result arriving mid-frame is kept
    p_keep_new_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ser_sel && cap_valid) |=> pend_vld);
endmodule

// File: rtl/result_port.sv
`timescale 1ns/1ps
// Module: result_port (top)
// Result output port: coding, parallel bus muxing, serial framing and
// bit clock selection. The shared bits carry bus data in parallel mode
// and serial configuration in serial mode.
// Assumes ser_sel and the configuration pins are static while a frame runs.
module result_port
    import result_port_pkg::*;
#(
    parameter int W  = RES_W,
    parameter int SS = SYNC_STAGES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            res_data,
    input  logic                    res_valid,
    input  logic                    fmt_straight,
    input  logic                    ser_sel,
    input  logic                    cs_n,
    input  logic                    rd_n,
    output logic [LO_W-1:0]         bus_lo,
    input  logic [MUX_W-1:0]        mux_in,
    output logic [MUX_W-1:0]        mux_out,
    output logic                    mux_oe,
    output logic [W-LO_W-MUX_W-1:0] bus_hi,
    output logic                    ser_dout,
    output logic                    ser_sync,
    output logic                    sclk_out,
    output logic                    sclk_oe,
    input  logic                    sclk_in
);
    logic [W-1:0] coded_now;
    logic [W-1:0] word_q;
    logic         ext_sel;
    logic         sync_inv;
    logic         sclk_inv;
    logic         launch;
    logic         frame_act;

    // Shared pins count as configuration only in serial mode.
    always_comb begin
        ext_sel  = ser_sel && mux_in[CFG_EXT_CLK];
        sync_inv = ser_sel && mux_in[CFG_SYNC_INV];
        sclk_inv = ser_sel && mux_in[CFG_SCLK_INV];
    end

    result_capture #(.W(W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .res_data     (res_data),
        .res_valid    (res_valid),
        .fmt_straight (fmt_straight),
        .coded_now    (coded_now),
        .word_q       (word_q)
    );

    par_bus_drv #(.W(W), .LO_W(LO_W), .MUX_W(MUX_W)) u_bus (
        .word_q  (word_q),
        .ser_sel (ser_sel),
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_lo  (bus_lo),
        .mux_out (mux_out),
        .mux_oe  (mux_oe),
        .bus_hi  (bus_hi)
    );

    ser_clk_unit #(.SYNC_STAGES(SS)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_sel   (ser_sel),
        .ext_sel   (ext_sel),
        .sclk_inv  (sclk_inv),
        .frame_act (frame_act),
        .sclk_in   (sclk_in),
        .launch    (launch),
        .sclk_out  (sclk_out),
        .sclk_oe   (sclk_oe)
    );

    ser_framer #(.W(W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_sel   (ser_sel),
        .cap_valid (res_valid),
        .cap_word  (coded_now),
        .launch    (launch),
        .sync_inv  (sync_inv),
        .ser_dout  (ser_dout),
        .ser_sync  (ser_sync),
        .frame_act (frame_act)
    );

    // R10: no frame activity in parallel mode
    p_par_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_sel && $past(!ser_sel)) |-> (!frame_act || $past(frame_act)));
endmodule

// File: tb/result_port_bench.sv
`timescale 1ns/1ps
// Bench for result_port: sweeps the coding, both ports, the strobe gating,
// all polarity settings and both clock sources. Expected values are
// computed arithmetically.
module result_port_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] res_data;
    logic        res_valid;
    logic        fmt_straight;
    logic        ser_sel;
    logic        cs_n;
    logic        rd_n;
    logic [3:0]  bus_lo;
    logic [2:0]  mux_in;
    logic [2:0]  mux_out;
    logic        mux_oe;
    logic [8:0]  bus_hi;
    logic        ser_dout;
    logic        ser_sync;
    logic        sclk_out;
    logic        sclk_oe;
    logic        sclk_in;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    result_port u_result_port (
        .clk (clk), .rst_n (rst_n), .res_data (res_data), .res_valid (res_valid),
        .fmt_straight (fmt_straight), .ser_sel (ser_sel), .cs_n (cs_n), .rd_n (rd_n),
        .bus_lo (bus_lo), .mux_in (mux_in), .mux_out (mux_out), .mux_oe (mux_oe),
        .bus_hi (bus_hi), .ser_dout (ser_dout), .ser_sync (ser_sync),
        .sclk_out (sclk_out), .sclk_oe (sclk_oe), .sclk_in (sclk_in)
    );

    function automatic logic [15:0] code_of(input logic [15:0] d, input logic s);
        return s ? d : (d ^ 16'h8000);
    endfunction

    function automatic logic [15:0] full_bus();
        return {bus_hi, mux_out, bus_lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Strobe one result; returns at the falling edge after the capture edge.
    task automatic send(input logic [15:0] d, input logic s);
        @(negedge clk);
        res_data = d; fmt_straight = s; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // Parallel read of one value under all strobe combinations.
    task automatic par_case(input logic [15:0] d, input logic s);
        logic [15:0] e;
        e = code_of(d, s);
        send(d, s);
        cs_n = 1'b0; rd_n = 1'b0; #0.5;
        chk(full_bus() == e, "R1 coded word on bus", 32'(full_bus()), 32'(e));
        cs_n = 1'b1; #0.5;
        chk(full_bus() == 16'h0, "R2 cs high blanks bus", 32'(full_bus()), 32'h0);
        cs_n = 1'b0; rd_n = 1'b1; #0.5;
        chk(full_bus() == 16'h0, "R2 rd high blanks bus", 32'(full_bus()), 32'h0);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    // One internal-clock frame with the given polarities.
    task automatic ser_int(input logic [15:0] d, input logic s, input logic si,
                           input logic ci);
        logic [15:0] e;
        e = code_of(d, s);
        @(negedge clk);
        mux_in = {ci, si, 1'b0};
        @(negedge clk);
        chk(ser_sync == si, "R7 idle frame level", 32'(ser_sync), 32'(si));
        chk(sclk_out == ci, "R8 idle clock level", 32'(sclk_out), 32'(ci));
        chk(sclk_oe == 1'b1, "R5 clock driven", 32'(sclk_oe), 32'h1);
        send(d, s);
        for (int k = 0; k < 32; k++) begin
            chk(ser_dout == e[15 - k/2], "R4 R5 serial bit", 32'(ser_dout),
                32'(e[15 - k/2]));
            chk(ser_sync == !si, "R7 active frame level", 32'(ser_sync), 32'(!si));
            chk(sclk_out == ((k % 2 == 1) ^ ci), "R8 R5 clock phase",
                32'(sclk_out), 32'((k % 2 == 1) ^ ci));
            @(negedge clk);
        end
        chk(ser_sync == si, "R5 frame over after 32 cycles", 32'(ser_sync), 32'(si));
        chk(ser_dout == 1'b0, "R4 data idle", 32'(ser_dout), 32'h0);
    endtask

    // One external-clock frame, four system cycles per half period.
    task automatic ser_ext(input logic [15:0] d, input logic s, input logic si,
                           input logic ci);
        logic [15:0] e;
        e = code_of(d, s);
        @(negedge clk);
        mux_in = {ci, si, 1'b1};
        sclk_in = ci;
        repeat (4) @(negedge clk);
        chk(sclk_oe == 1'b0, "R6 clock pin released", 32'(sclk_oe), 32'h0);
        send(d, s);
        for (int i = 0; i < 16; i++) begin
            chk(ser_dout == e[15 - i], "R6 bit before rise", 32'(ser_dout),
                32'(e[15 - i]));
            chk(ser_sync == !si, "R7 frame active ext", 32'(ser_sync), 32'(!si));
            sclk_in = !ci;
            repeat (4) @(negedge clk);
            chk(ser_dout == e[15 - i], "R6 rise does not advance", 32'(ser_dout),
                32'(e[15 - i]));
            sclk_in = ci;
            repeat (4) @(negedge clk);
        end
        chk(ser_sync == si, "R6 frame over after 16 falls", 32'(ser_sync), 32'(si));
        chk(ser_dout == 1'b0, "R4 data idle ext", 32'(ser_dout), 32'h0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] a, b, c, ea, ec;
        rst_n = 1'b0; res_data = '0; res_valid = 1'b0; fmt_straight = 1'b1;
        ser_sel = 1'b0; cs_n = 1'b1; rd_n = 1'b1; mux_in = '0; sclk_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; #0.5;
        chk(full_bus() == 16'h0, "R2 reset word zero", 32'(full_bus()), 32'h0);
        chk(mux_oe == 1'b1, "R3 shared bits driven in parallel", 32'(mux_oe), 32'h1);
        cs_n = 1'b1; rd_n = 1'b1;

        // R1/R2 sweep: corner codes plus a spread of patterns, both codings.
        par_case(16'h0000, 1'b0); par_case(16'h0000, 1'b1);
        par_case(16'h7FFF, 1'b0); par_case(16'h8000, 1'b0);
        par_case(16'hFFFF, 1'b1); par_case(16'hFFFF, 1'b0);
        for (int i = 0; i < 64; i++) begin
            par_case(16'(i * 1031) ^ 16'(i << 9), i[0]);
        end

        // R10: parallel mode strobe must not start a frame.
        send(16'hA5A5, 1'b1);
        chk(ser_dout == 1'b0, "R10 no frame in parallel", 32'(ser_dout), 32'h0);
        chk(ser_sync == 1'b0, "R10 no frame signal in parallel", 32'(ser_sync), 32'h0);

        // R3: serial mode bus behaviour.
        @(negedge clk);
        ser_sel = 1'b1; mux_in = 3'b000;
        send(16'h3C5A, 1'b0);
        cs_n = 1'b0; rd_n = 1'b0; #0.5;
        chk(bus_lo == 4'hA, "R3 low nibble in serial", 32'(bus_lo), 32'hA);
        chk(mux_oe == 1'b0, "R3 shared bits released", 32'(mux_oe), 32'h0);
        chk(bus_hi == 9'h0 && mux_out == 3'h0, "R3 upper bus quiet",
            32'({bus_hi, mux_out}), 32'h0);
        cs_n = 1'b1; rd_n = 1'b1;
        repeat (40) @(negedge clk);

        // R4/R5/R7/R8: all polarity combinations, internal clock.
        for (int p = 0; p < 4; p++) begin
            ser_int(16'h8001 ^ 16'(p * 4369), p[0], p[0], p[1]);
            ser_int(16'h7F0E + 16'(p), !p[0], p[1], p[0]);
        end

        // R9: two results during a frame; the newest is sent next.
        a = 16'hC3A1; b = 16'h1111; c = 16'h5E6B;
        ea = code_of(a, 1'b1); ec = code_of(c, 1'b1);
        @(negedge clk);
        mux_in = 3'b000;
        send(a, 1'b1);
        for (int k = 0; k < 32; k++) begin
            if (k == 5)  begin res_data = b; res_valid = 1'b1; end
            if (k == 6)  res_valid = 1'b0;
            if (k == 10) begin res_data = c; res_valid = 1'b1; end
            if (k == 11) res_valid = 1'b0;
            chk(ser_dout == ea[15 - k/2], "R9 running frame intact", 32'(ser_dout),
                32'(ea[15 - k/2]));
            @(negedge clk);
        end
        chk(ser_sync == 1'b0, "R9 idle gap between frames", 32'(ser_sync), 32'h0);
        @(negedge clk);
        for (int k = 0; k < 32; k++) begin
            chk(ser_dout == ec[15 - k/2], "R9 newest held result sent",
                32'(ser_dout), 32'(ec[15 - k/2]));
            chk(ser_sync == 1'b1, "R9 held frame active", 32'(ser_sync), 32'h1);
            @(negedge clk);
        end
        chk(ser_sync == 1'b0, "R9 nothing more queued", 32'(ser_sync), 32'h0);
        repeat (4) @(negedge clk);
        chk(ser_sync == 1'b0, "R9 queue empty later", 32'(ser_sync), 32'h0);

        // R6: external clock, all polarity combinations.
        for (int p = 0; p < 4; p++) begin
            ser_ext(16'hB00D ^ 16'(p * 257), p[1], p[0], p[1]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule